// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one decoded load-multiple or store-multiple instruction and expands it into a stream of simple micro-ops, one per cycle. The instruction arrives as a 16-bit register list, a base register index and a handful of mode flags: direction (ascending or descending), pre-index, writeback, load/store and a user/status flag. The sequencer first snapshots the base into a hidden temporary register. It then walks the register list from the lowest set bit to the highest and issues one memory micro-op per bit, each addressed relative to that temporary. A base-update micro-op can close the sequence.

Both edges of the block use a valid/ready handshake. An instruction is taken only when `in_valid` and `in_ready` are both high, and `in_ready` is high only while the sequencer is idle. A micro-op transfers on any cycle where `uop_valid` and `uop_ready` are both high. While `uop_ready` is low, every micro-op field stays unchanged and the sequence does not advance. The micro-op register fields are one bit wider than an architectural index. Index 16 names the hidden temporary, and indices 24 to 30 name the user-bank copies of registers 8 to 14.

Top module: `lsm_uop_seq`

## Requirements
- R1: `in_ready` is 1 exactly when the sequencer is idle. While it is 0, `in_valid` and the instruction fields have no effect on the micro-ops produced.
- R2: The first micro-op of every instruction is a copy-base with opcode 0, rd = 16, rb = the base index, imm = 0 and add = 1.
- R3: There is one memory micro-op per set list bit, issued from the lowest index to the highest. Each has rb = 16. The opcode is 1 for a load and 3 for a store, and rd is the register index, remapped where R7 applies.
- R4: The first memory offset is 0 when ascending and 4·n − 4 when descending, where n is the number of set bits. Pre-index adds 4 to it. The add flag of every memory micro-op equals the direction bit (1 = ascending).
- R5: Each following memory micro-op's offset is 4 higher than the previous one when ascending, and 4 lower when descending.
- R6: With writeback set, a final micro-op has rd = rb = base and imm = 4·n. Its opcode is 4 (add-immediate) with add = 1 when ascending, and 5 (subtract-immediate) with add = 0 when descending.
- R7: With the user flag set and list bit 15 clear, transferred registers 8..14 appear as 24..30. All other indices are left unchanged.
- R8: With the user flag set, a load, and list bit 15 set, register 15 is issued with opcode 2 (load-with-return). No register is remapped in this case.
- R9: Exactly the final micro-op has last = 1. An instruction yields 1 + n micro-ops, plus one more with writeback.
- R10: An empty list yields only the copy-base micro-op, followed by a writeback micro-op with imm 0 if writeback is set.
- R11: While `uop_valid` is 1 and `uop_ready` is 0, every micro-op output holds its value into the next cycle.
- R12: A synchronous reset leaves the block idle, with `in_ready` = 1 and `uop_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction can be taken |
| in_reglist | input | 16 | Register list, bit i selects register i |
| in_base | input | 4 | Base register index |
| in_up | input | 1 | 1 = ascending addresses |
| in_pre | input | 1 | 1 = pre-indexed |
| in_wb | input | 1 | 1 = update base afterwards |
| in_load | input | 1 | 1 = load, 0 = store |
| in_user | input | 1 | User-bank / status-restore flag |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | Opcode: 0 copy, 1 load, 2 load-with-return, 3 store, 4 add-imm, 5 sub-imm |
| uop_rd | output | 5 | Destination or source register |
| uop_rb | output | 5 | Base register of the micro-op |
| uop_imm | output | 8 | Immediate magnitude |
| uop_add | output | 1 | 1 = add the immediate, 0 = subtract it |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The assertions check the following on every cycle: the handshake rules (busy implies not ready, stalled outputs hold, a taken last micro-op returns the block to idle) and the reset state. They also check that an accepted instruction opens with a copy-base, that memory micro-ops address the temporary, and that consecutive memory offsets step by 4 in the chosen direction. The scoreboard alone can confirm the full content of each sequence. That covers the list order, the descending and pre-index start offsets, the user-bank remap against the load-with-return case, the writeback immediate and the empty-list forms. It also shows that inputs presented while busy leave the stream untouched.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [2:0] {
    OP_COPY    = 3'd0,
    OP_LOAD    = 3'd1,
    OP_LOADRET = 3'd2,
    OP_STORE   = 3'd3,
    OP_ADDI    = 3'd4,
    OP_SUBI    = 3'd5
  } uop_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_XFER,
    ST_WB
  } seq_state_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end

endmodule

// File: rtl/lsm_lowest_pick.sv
module lsm_lowest_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             single
);

  logic [N-1:0] seen_below;

  assign seen_below[0] = 1'b0;

  generate
    for (genvar g = 1; g < N; g++) begin : g_chain
      assign seen_below[g] = seen_below[g-1] | vec[g-1];
    end
  endgenerate

  assign onehot = vec & ~seen_below;
  assign any    = |vec;
  assign single = any && ((vec & ~onehot) == '0);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/lsm_offset_gen.sv
module lsm_offset_gen #(
  parameter int CNT_W = 5,
  parameter int OFF_W = 8
) (
  input  logic [CNT_W-1:0] count,
  input  logic             up,
  input  logic             pre,
  output logic [OFF_W-1:0] start_off,
  output logic [OFF_W-1:0] total
);

  localparam logic [OFF_W-1:0] WORD = OFF_W'(4);

  logic [OFF_W-1:0] base_off;

  always_comb begin
    total     = OFF_W'(count) << 2;
    base_off  = up ? '0 : (total - WORD);
    start_off = pre ? (base_off + WORD) : base_off;
  end

endmodule

// File: rtl/lsm_reg_remap.sv
module lsm_reg_remap #(
  parameter int IDX_W     = 4,
  parameter int UREG_W    = 5,
  parameter int BANK_LO   = 8,
  parameter int BANK_HI   = 14,
  parameter int BANK_BASE = 24
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              en,
  output logic [UREG_W-1:0] ureg
);

  logic in_bank;

  always_comb begin
    in_bank = (int'(idx) >= BANK_LO) && (int'(idx) <= BANK_HI);
    if (en && in_bank) begin
      ureg = UREG_W'(BANK_BASE) + UREG_W'(idx) - UREG_W'(BANK_LO);
    end else begin
      ureg = {{(UREG_W-IDX_W){1'b0}}, idx};
    end
  end

endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq #(
  parameter int NREGS     = 16,
  parameter int OFF_W     = 8,
  parameter int TEMP_REG  = 16,
  parameter int BANK_LO   = 8,
  parameter int BANK_HI   = 14,
  parameter int BANK_BASE = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NREGS-1:0]           in_reglist,
  input  logic [$clog2(NREGS)-1:0]   in_base,
  input  logic                       in_up,
  input  logic                       in_pre,
  input  logic                       in_wb,
  input  logic                       in_load,
  input  logic                       in_user,
  output logic                       uop_valid,
  input  logic                       uop_ready,
  output logic [2:0]                 uop_op,
  output logic [$clog2(NREGS):0]     uop_rd,
  output logic [$clog2(NREGS):0]     uop_rb,
  output logic [OFF_W-1:0]           uop_imm,
  output logic                       uop_add,
  output logic                       uop_last
);

  import lsm_pkg::*;

  localparam int IDX_W  = $clog2(NREGS);
  localparam int UREG_W = IDX_W + 1;
  localparam int CNT_W  = $clog2(NREGS + 1);
  localparam int PC_IDX = NREGS - 1;
  localparam logic [UREG_W-1:0] TEMP = UREG_W'(TEMP_REG);
  localparam logic [OFF_W-1:0]  WORD = OFF_W'(4);

  seq_state_e        state_q;
  logic [NREGS-1:0]  mask_q;
  logic [IDX_W-1:0]  base_q;
  logic              up_q;
  logic              wb_q;
  logic              load_q;
  logic              user_q;
  logic              pc_listed_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  wbimm_q;

  logic [CNT_W-1:0]  in_count;
  logic [OFF_W-1:0]  in_start;
  logic [OFF_W-1:0]  in_total;
  logic [NREGS-1:0]  pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic              pick_single;
  logic [UREG_W-1:0] xfer_reg;
  logic              accept;
  logic              fire;
  logic              is_mem;

  lsm_popcount #(.N(NREGS), .CNT_W(CNT_W)) i_count (
    .vec   (in_reglist),
    .count (in_count)
  );

  lsm_offset_gen #(.CNT_W(CNT_W), .OFF_W(OFF_W)) i_offs (
    .count     (in_count),
    .up        (in_up),
    .pre       (in_pre),
    .start_off (in_start),
    .total     (in_total)
  );

  lsm_lowest_pick #(.N(NREGS), .IDX_W(IDX_W)) i_pick (
    .vec    (mask_q),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any),
    .single (pick_single)
  );

  lsm_reg_remap #(
    .IDX_W(IDX_W), .UREG_W(UREG_W),
    .BANK_LO(BANK_LO), .BANK_HI(BANK_HI), .BANK_BASE(BANK_BASE)
  ) i_remap (
    .idx  (pick_idx),
    .en   (user_q && !pc_listed_q),
    .ureg (xfer_reg)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign uop_valid = (state_q != ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign fire      = uop_valid && uop_ready;

  // Micro-op fields decoded from the held sequence state
  always_comb begin
    uop_op   = OP_COPY;
    uop_rd   = TEMP;
    uop_rb   = {1'b0, base_q};
    uop_imm  = '0;
    uop_add  = 1'b1;
    uop_last = 1'b0;
    unique case (state_q)
      ST_COPY: begin
        uop_last = !pick_any && !wb_q;
      end
      ST_XFER: begin
        uop_rd  = xfer_reg;
        uop_rb  = TEMP;
        uop_imm = off_q;
        uop_add = up_q;
        if (!load_q) begin
          uop_op = OP_STORE;
        end else if (user_q && (int'(pick_idx) == PC_IDX)) begin
          uop_op = OP_LOADRET;
        end else begin
          uop_op = OP_LOAD;
        end
        uop_last = pick_single && !wb_q;
      end
      ST_WB: begin
        uop_op   = up_q ? OP_ADDI : OP_SUBI;
        uop_rd   = {1'b0, base_q};
        uop_imm  = wbimm_q;
        uop_add  = up_q;
        uop_last = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mask_q      <= '0;
      base_q      <= '0;
      up_q        <= 1'b0;
      wb_q        <= 1'b0;
      load_q      <= 1'b0;
      user_q      <= 1'b0;
      pc_listed_q <= 1'b0;
      off_q       <= '0;
      wbimm_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_COPY;
            mask_q      <= in_reglist;
            base_q      <= in_base;
            up_q        <= in_up;
            wb_q        <= in_wb;
            load_q      <= in_load;
            user_q      <= in_user;
            pc_listed_q <= in_reglist[PC_IDX];
            off_q       <= in_start;
            wbimm_q     <= in_total;
          end
        end
        ST_COPY: begin
          if (fire) begin
            if (pick_any)  state_q <= ST_XFER;
            else if (wb_q) state_q <= ST_WB;
            else           state_q <= ST_IDLE;
          end
        end
        ST_XFER: begin
          if (fire) begin
            mask_q <= mask_q & ~pick_oh;
            off_q  <= up_q ? (off_q + WORD) : (off_q - WORD);
            if (pick_single) state_q <= wb_q ? ST_WB : ST_IDLE;
          end
        end
        ST_WB: begin
          if (fire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign is_mem = (uop_op == OP_LOAD) || (uop_op == OP_LOADRET) || (uop_op == OP_STORE);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> !in_ready); // R1

  AST_OPENS_WITH_COPY: assert property (@(posedge clk) disable iff (rst)
    accept |=> (uop_valid && uop_op == OP_COPY && uop_rd == TEMP && uop_imm == '0)); // R2

  AST_MEM_USES_TEMP: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && is_mem) |-> (uop_rb == TEMP)); // R3

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
    (fire && is_mem && !uop_last) |=>
      (!is_mem || uop_imm == (uop_add ? OFF_W'($past(uop_imm) + WORD)
                                      : OFF_W'($past(uop_imm) - WORD)))); // R5

  AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fire && uop_last) |=> in_ready); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_ready) |=>
      (uop_valid && $stable(uop_op) && $stable(uop_rd) && $stable(uop_rb) &&
       $stable(uop_imm) && $stable(uop_add) && $stable(uop_last))); // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (in_ready && !uop_valid)); // R12

endmodule

// File: tb/test_lsm_uop_seq.sv
module test_lsm_uop_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_reglist = '0;
  logic [3:0]  in_base = '0;
  logic        in_up = 1'b0, in_pre = 1'b0, in_wb = 1'b0, in_load = 1'b0, in_user = 1'b0;
  logic        uop_valid;
  logic        uop_ready = 1'b1;
  logic [2:0]  uop_op;
  logic [4:0]  uop_rd, uop_rb;
  logic [7:0]  uop_imm;
  logic        uop_add, uop_last;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] rd;
    logic [4:0] rb;
    logic [7:0] imm;
    logic       add;
    logic       last;
  } item_t;

  item_t q_exp[$];
  string q_tag[$];
  int    checks = 0;
  int    errors = 0;
  logic  stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic  held_chk = 1'b0;
  item_t held_val;

  always #5 clk = ~clk;

  lsm_uop_seq i_lsm_uop_seq (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_reglist(in_reglist), .in_base(in_base),
    .in_up(in_up), .in_pre(in_pre), .in_wb(in_wb), .in_load(in_load), .in_user(in_user),
    .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_op(uop_op), .uop_rd(uop_rd), .uop_rb(uop_rb),
    .uop_imm(uop_imm), .uop_add(uop_add), .uop_last(uop_last)
  );

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    uop_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  function automatic item_t cur_item();
    return '{op: uop_op, rd: uop_rd, rb: uop_rb, imm: uop_imm, add: uop_add, last: uop_last};
  endfunction

  // Monitor: compares stalled holds and every transferred micro-op
  always @(negedge clk) begin
    if (!rst) begin
      if (held_chk) begin
        checks++;
        if (cur_item() !== held_val || !uop_valid) begin
          errors++;
          $display("FAIL R11 stalled output changed: got %h expected %h", cur_item(), held_val);
        end
      end
      held_chk = uop_valid && !uop_ready;
      held_val = cur_item();
      if (uop_valid && uop_ready) begin
        checks++;
        if (q_exp.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected micro-op: got %h expected none", cur_item());
        end else begin
          item_t e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          if (cur_item() !== e) begin
            errors++;
            $display("FAIL %s op/rd/rb/imm/add/last: got %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
                     t, uop_op, uop_rd, uop_rb, uop_imm, uop_add, uop_last,
                     e.op, e.rd, e.rb, e.imm, e.add, e.last);
          end
        end
      end
    end
  end

  task automatic push(input item_t it, input string tag);
    q_exp.push_back(it);
    q_tag.push_back(tag);
  endtask

  // Driver: builds the expected stream from the requirements, then offers the instruction
  task automatic issue(input logic [15:0] list, input logic [3:0] base,
                       input logic up, input logic pre, input logic wb,
                       input logic load, input logic user, input bit junk);
    int n;
    logic [7:0] off;
    logic [4:0] rd;
    logic [2:0] op;
    int left;
    string tag;
    n = $countones(list);
    off = up ? 8'd0 : 8'(4 * n - 4);
    if (pre) off = off + 8'd4;
    push('{op: 3'd0, rd: 5'd16, rb: {1'b0, base}, imm: 8'd0, add: 1'b1,
           last: (n == 0) && !wb}, (n == 0) ? "R2 R10" : "R2");
    left = n;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        left--;
        rd  = 5'(i);
        tag = "R3 R4 R5";
        if (user && !list[15] && i >= 8 && i <= 14) begin
          rd  = 5'(24 + i - 8);
          tag = "R7";
        end
        if (!load) op = 3'd3;
        else if (user && i == 15) begin
          op  = 3'd2;
          tag = "R8";
        end else op = 3'd1;
        push('{op: op, rd: rd, rb: 5'd16, imm: off, add: up,
               last: (left == 0) && !wb}, tag);
        off = up ? off + 8'd4 : off - 8'd4;
      end
    end
    if (wb) push('{op: up ? 3'd4 : 3'd5, rd: {1'b0, base}, rb: {1'b0, base},
                   imm: 8'(4 * n), add: up, last: 1'b1}, "R6 R9");

    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_reglist = list; in_base = base; in_up = up; in_pre = pre;
    in_wb = wb; in_load = load; in_user = user; in_valid = 1'b1;
    @(posedge clk);
    #1;
    if (junk) begin
      in_reglist = ~list; in_base = ~base; in_up = ~up; in_load = ~load; in_wb = ~wb;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b0) begin
          errors++;
          $display("FAIL R1 in_ready while busy: got %b expected 0", in_ready);
        end
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q_exp.size() != 0 || !in_ready) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1 || uop_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset state: got ready=%b valid=%b expected ready=1 valid=0",
               in_ready, uop_valid);
    end
    rst = 1'b0;

    issue(16'h0029, 4'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R3 R4 ascending post store
    issue(16'h0086, 4'd13, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R4 R5 R6 descending pre load
    drain();
    stall_mode = 1'b1;
    issue(16'h4304, 4'd1,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R7 user store remap
    issue(16'h8100, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R8 load-with-return
    issue(16'h2400, 4'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R7 user load remap
    issue(16'h0000, 4'd5,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R10 empty with writeback
    issue(16'h0000, 4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R10 empty alone
    issue(16'hFFFF, 4'd4,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); // R1 R4 R6 full list, busy junk
    issue(16'h8008, 4'd7,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R8 user store with PC
    drain();
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);

    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R9 missing micro-ops: got %0d left expected 0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule